// File: doc/BRIEF.md
# Receive Frame Ready Controller

This block sits between the byte-wide receive output of one Ethernet MAC and a shared 64-bit host bus. Incoming bytes are packed into 64-bit words, each with a flag for every byte lane, and stored in a small word buffer. A per-channel ready output tells the host arbiter when to service the channel. It asserts when a full burst of data is waiting or when a complete frame has been stored. The host then pulls one word per cycle with a read strobe.

Two options change how frames are delivered. With the runt hold-off enabled, nothing of a frame becomes visible until it reaches the minimum legal size, and frames that end below that size are dropped by rewinding the write pointer. With status append enabled, one extra word follows each frame, carrying its length and error flags. If the buffer fills while a frame is arriving, the unread part of that frame is dropped, the rest of its bytes are ignored, and a one-cycle overflow flag is raised.

Top module: `rx_frame_ready`

## Requirements
- R1: After reset, host_ready, host_bvalid, host_eof and ovf_flag are all 0.
- R2: Bytes are packed in arrival order: the first byte of a word lands in lane 0 (host_data[7:0]), and each following byte lands in the next higher lane.
- R3: A full word has host_bvalid = 8'hFF. The last data word of a frame of length L sets only its L mod 8 low lanes (all 8 when L mod 8 is 0), filled from lane 0 upward, and its unused lanes read as zero.
- R4: cfg_burst_sel = 0 selects a 32-byte burst (4 words) and cfg_burst_sel = 1 selects a 64-byte burst (8 words). host_ready rises in the cycle after the byte that brings the readable words up to the burst.
- R5: host_ready rises in the cycle after the last byte of a delivered frame is accepted, even when the frame is shorter than the burst.
- R6: With cfg_holdoff_en = 1, no word of a frame is readable and host_ready stays low for it until 64 bytes of it have arrived. A frame ending with fewer than 64 bytes is removed completely.
- R7: With cfg_holdoff_en = 0, frames shorter than 64 bytes are delivered in full.
- R8: With cfg_status_en = 1, one extra word follows the last data word of each delivered frame. It holds the length in bits [15:0], the CRC error input sampled with the last byte in bit 16, and a flag set when the length is below 64 in bit 17. All other bits are 0, and host_bvalid is 8'hFF.
- R9: host_eof is 1 only on the final word of a frame: the status word when status append is on, otherwise the last data word.
- R10: Each cycle with host_rd high and a readable word removes exactly one word. host_rd with no readable word has no effect.
- R11: When a frame needs more words than the buffer has free, its unread words are dropped, the rest of its bytes are ignored, and ovf_flag pulses high for one cycle. Frames stored earlier, and the next frame, are delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_sel | input | 1 | Burst size: 0 = 32 bytes, 1 = 64 bytes |
| cfg_holdoff_en | input | 1 | Withhold frames until minimum size; drop short frames |
| cfg_status_en | input | 1 | Append a status word after each frame |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_crc_err | input | 1 | CRC error for the frame, sampled with the last byte |
| host_rd | input | 1 | Host read strobe, one word per cycle |
| host_ready | output | 1 | Burst or end of frame available |
| host_data | output | 64 | Word at the head of the buffer |
| host_bvalid | output | 8 | Valid flag per byte lane; 0 when nothing is readable |
| host_eof | output | 1 | Head word is the final word of its frame |
| ovf_flag | output | 1 | One-cycle pulse on a buffer overflow |

## Verification
The hardest condition to reach from the ports is an overflow that lands in the middle of a frame while an earlier complete frame is still unread. The bench stalls the host, stores a short frame, and then sends a frame longer than the whole buffer. It then sends a third frame and drains everything, expecting the first and third frames byte for byte and exactly one overflow pulse. Runt removal is reached by toggling the hold-off between frames of random length on both sides of 64 bytes.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
   localparam int LANES    = 8;
   localparam int BYTE_W   = 8;
   localparam int WORD_W   = LANES * BYTE_W;
   localparam int LEN_W    = 16;
   localparam int CRC_BIT  = 16;
   localparam int RUNT_BIT = 17;

   typedef struct packed {
      logic               eof;
      logic [LANES-1:0]   bvalid;
      logic [WORD_W-1:0]  data;
   } rfr_word_t;

   function automatic logic [WORD_W-1:0] make_status(input logic [LEN_W-1:0] len,
                                                     input logic crc, input logic runt);
      logic [WORD_W-1:0] s;
      s = '0;
      s[LEN_W-1:0] = len;
      s[CRC_BIT]   = crc;
      s[RUNT_BIT]  = runt;
      return s;
   endfunction
endpackage

// File: rtl/rfr_packer.sv
module rfr_packer
   import rfr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               byte_en,
   input  logic [BYTE_W-1:0]  byte_in,
   input  logic               byte_last,
   input  logic               flush,
   output logic               acc,
   output logic               word_done,
   output logic [WORD_W-1:0]  word_data,
   output logic [LANES-1:0]   word_bvalid,
   output logic [LEN_W-1:0]   len_q,
   output logic [LEN_W-1:0]   len_now
);
   localparam int LW = $clog2(LANES);

   logic [LW-1:0]     lane_q;
   logic [WORD_W-1:0] buf_q;
   logic              drop_q;

   assign acc       = byte_en && !drop_q;
   assign word_done = acc && (byte_last || lane_q == LW'(LANES-1));
   assign len_now   = len_q + LEN_W'(1);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign word_data[i*BYTE_W +: BYTE_W] = (lane_q == LW'(i)) ? byte_in
                                                                : buf_q[i*BYTE_W +: BYTE_W];
      assign word_bvalid[i] = (LW'(i) <= lane_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lane_q <= '0;
         buf_q  <= '0;
         len_q  <= '0;
         drop_q <= 1'b0;
      end else if (flush) begin
         lane_q <= '0;
         buf_q  <= '0;
         len_q  <= '0;
         drop_q <= !byte_last;
      end else if (drop_q) begin
         if (byte_en && byte_last) drop_q <= 1'b0;
      end else if (acc) begin
         lane_q <= byte_last ? '0 : lane_q + LW'(1);
         buf_q  <= word_done ? '0 : word_data;
         len_q  <= byte_last ? '0 : len_now;
      end
   end
endmodule

// File: rtl/rfr_store.sv
module rfr_store
   import rfr_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we0,
   input  logic [AW-1:0] addr0,
   input  rfr_word_t     din0,
   input  logic          we1,
   input  logic [AW-1:0] addr1,
   input  rfr_word_t     din1,
   input  logic [AW-1:0] raddr,
   output rfr_word_t     dout
);
   rfr_word_t mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)                          mem[i] <= '0;
         else if (we0 && addr0 == AW'(i))     mem[i] <= din0;
         else if (we1 && addr1 == AW'(i))     mem[i] <= din1;
      end
   end

   assign dout = mem[raddr];
endmodule

// File: rtl/rfr_ready_gen.sv
module rfr_ready_gen #(
   parameter int PW       = 5,
   parameter int BURST_LO = 32,
   parameter int BURST_HI = 64
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] avail,
   input  logic          burst_sel,
   input  logic          eof_inc,
   input  logic          eof_dec,
   output logic [PW-1:0] eof_cnt,
   output logic          ready
);
   logic [PW-1:0] thr;

   if (BURST_LO == BURST_HI) begin : g_fixed
      assign thr = PW'(BURST_LO / 8);
      logic unused_sel;
      assign unused_sel = burst_sel;
   end else begin : g_sel
      assign thr = burst_sel ? PW'(BURST_HI / 8) : PW'(BURST_LO / 8);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) eof_cnt <= '0;
      else        eof_cnt <= eof_cnt + PW'(eof_inc) - PW'(eof_dec);
   end

   assign ready = (avail >= thr) || (eof_cnt != '0);
endmodule

// File: rtl/rx_frame_ready.sv
module rx_frame_ready
   import rfr_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int MIN_FRAME = 64,
   parameter int BURST_LO  = 32,
   parameter int BURST_HI  = 64
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_burst_sel,
   input  logic              cfg_holdoff_en,
   input  logic              cfg_status_en,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_last,
   input  logic              rx_crc_err,
   input  logic              host_rd,
   output logic              host_ready,
   output logic [WORD_W-1:0] host_data,
   output logic [LANES-1:0]  host_bvalid,
   output logic              host_eof,
   output logic              ovf_flag
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (BURST_LO % 8 != 0 || BURST_HI % 8 != 0 || BURST_HI / 8 > DEPTH || BURST_LO < 8) begin : g_bad_burst
      $error("burst sizes must be whole words that fit the buffer");
   end
   if (MIN_FRAME < 1 || MIN_FRAME >= (1 << LEN_W)) begin : g_bad_min
      $error("MIN_FRAME out of range for the length field");
   end

   logic              acc, word_done;
   logic [WORD_W-1:0] word_data;
   logic [LANES-1:0]  word_bvalid;
   logic [LEN_W-1:0]  len_q, len_now;
   logic [PW-1:0]     wr_q, rd_q, fs_q;
   logic [PW-1:0]     used, free_w, pub_end, avail, rd_nxt, target;
   logic [PW-1:0]     eof_cnt;
   logic [1:0]        need;
   logic              last_b, runt_now, discard, ovf, expose, rd_fire, commit;
   logic              ovf_q;
   rfr_word_t         din0, din1, head;

   rfr_packer u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_en    (rx_valid),
      .byte_in    (rx_data),
      .byte_last  (rx_last),
      .flush      (ovf),
      .acc        (acc),
      .word_done  (word_done),
      .word_data  (word_data),
      .word_bvalid(word_bvalid),
      .len_q      (len_q),
      .len_now    (len_now)
   );

   assign last_b   = acc && rx_last;
   assign runt_now = len_now < LEN_W'(MIN_FRAME);
   assign discard  = last_b && cfg_holdoff_en && runt_now;
   assign need     = (word_done && !discard) ? ((last_b && cfg_status_en) ? 2'd2 : 2'd1) : 2'd0;

   assign used     = wr_q - rd_q;
   assign free_w   = PW'(DEPTH) - used;
   assign ovf      = PW'(need) > free_w;

   assign expose   = !cfg_holdoff_en || (len_q >= LEN_W'(MIN_FRAME));
   assign pub_end  = expose ? wr_q : fs_q;
   assign avail    = pub_end - rd_q;
   assign rd_fire  = host_rd && (avail != '0);
   assign rd_nxt   = rd_q + PW'(rd_fire);
   assign target   = ((rd_nxt - fs_q) <= (wr_q - fs_q)) ? rd_nxt : fs_q;
   assign commit   = last_b && !discard && !ovf;

   assign din0.eof    = last_b && !cfg_status_en;
   assign din0.bvalid = word_bvalid;
   assign din0.data   = word_data;
   assign din1.eof    = 1'b1;
   assign din1.bvalid = '1;
   assign din1.data   = make_status(len_now, rx_crc_err, runt_now);

   rfr_store #(.DEPTH(DEPTH)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .we0  ((need != 2'd0) && !ovf),
      .addr0(wr_q[AW-1:0]),
      .din0 (din0),
      .we1  ((need == 2'd2) && !ovf),
      .addr1(AW'(wr_q + PW'(1))),
      .din1 (din1),
      .raddr(rd_q[AW-1:0]),
      .dout (head)
   );

   rfr_ready_gen #(.PW(PW), .BURST_LO(BURST_LO), .BURST_HI(BURST_HI)) u_rdy (
      .clk      (clk),
      .rst_n    (rst_n),
      .avail    (avail),
      .burst_sel(cfg_burst_sel),
      .eof_inc  (commit),
      .eof_dec  (rd_fire && head.eof),
      .eof_cnt  (eof_cnt),
      .ready    (host_ready)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         fs_q  <= '0;
         ovf_q <= 1'b0;
      end else begin
         rd_q  <= rd_nxt;
         ovf_q <= ovf;
         if (ovf) begin
            wr_q <= target;
            fs_q <= target;
         end else if (discard) begin
            wr_q <= fs_q;
         end else begin
            wr_q <= wr_q + PW'(need);
            if (last_b) fs_q <= wr_q + PW'(need);
         end
      end
   end

   assign host_data   = (avail != '0) ? head.data   : '0;
   assign host_bvalid = (avail != '0) ? head.bvalid : '0;
   assign host_eof    = (avail != '0) && head.eof;
   assign ovf_flag    = ovf_q;
endmodule

// File: rtl/rx_frame_ready_chk.sv
module rx_frame_ready_chk
   import rfr_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int MIN_FRAME = 64,
   parameter int PW        = 5
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_holdoff_en,
   input logic              cfg_status_en,
   input logic              host_ready,
   input logic [WORD_W-1:0] host_data,
   input logic [LANES-1:0]  host_bvalid,
   input logic              host_eof,
   input logic [PW-1:0]     wr_q,
   input logic [PW-1:0]     rd_q,
   input logic [PW-1:0]     eof_cnt,
   input logic [LEN_W-1:0]  len_q
);
   logic [LANES:0] bv_inc;
   assign bv_inc = {1'b0, host_bvalid} + (LANES+1)'(1);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_q - rd_q) <= PW'(DEPTH)); // R11
   AST_BVALID_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      (host_bvalid != '0) |-> ((bv_inc[LANES-1:0] & host_bvalid) == '0)); // R3
   AST_READY_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> (host_bvalid != '0)); // R4
   AST_EOF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      eof_cnt <= (wr_q - rd_q)); // R5
   AST_RUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_holdoff_en && eof_cnt == '0 && len_q < LEN_W'(MIN_FRAME)) |-> !host_ready); // R6
   AST_STATUS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_status_en && host_eof) |-> (host_data[WORD_W-1:RUNT_BIT+1] == '0 && host_bvalid == '1)); // R8
endmodule

bind rx_frame_ready rx_frame_ready_chk #(.DEPTH(DEPTH), .MIN_FRAME(MIN_FRAME), .PW(PW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_holdoff_en(cfg_holdoff_en),
   .cfg_status_en (cfg_status_en),
   .host_ready    (host_ready),
   .host_data     (host_data),
   .host_bvalid   (host_bvalid),
   .host_eof      (host_eof),
   .wr_q          (wr_q),
   .rd_q          (rd_q),
   .eof_cnt       (eof_cnt),
   .len_q         (len_q)
);

// File: tb/rx_frame_ready_tb.sv
`timescale 1ns/1ps
module rx_frame_ready_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_burst_sel = 1'b0, cfg_holdoff_en = 1'b0, cfg_status_en = 1'b0;
   logic        rx_valid = 1'b0, rx_last = 1'b0, rx_crc_err = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        host_rd = 1'b0;
   logic        host_ready, host_eof, ovf_flag;
   logic [63:0] host_data;
   logic [7:0]  host_bvalid;

   int n_chk = 0, n_fail = 0, ovf_seen = 0;
   logic [7:0] fr [256];

   always #2 clk = ~clk;

   rx_frame_ready u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_burst_sel(cfg_burst_sel),
      .cfg_holdoff_en(cfg_holdoff_en), .cfg_status_en(cfg_status_en),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_crc_err(rx_crc_err),
      .host_rd(host_rd), .host_ready(host_ready), .host_data(host_data),
      .host_bvalid(host_bvalid), .host_eof(host_eof), .ovf_flag(ovf_flag)
   );

   always @(negedge clk) if (rst_n && ovf_flag) ovf_seen++;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_data(input int len, input int w);
      logic [63:0] d = '0;
      for (int k = 0; k < 8; k++)
         if (w*8 + k < len) d[k*8 +: 8] = fr[w*8 + k];
      return d;
   endfunction

   function automatic logic [7:0] exp_bv(input int len, input int w);
      int n = len - w*8;
      if (n >= 8) return 8'hFF;
      return 8'((1 << n) - 1);
   endfunction

   function automatic logic [63:0] exp_status(input int len, input bit crc);
      logic [63:0] s = '0;
      s[15:0] = 16'(len);
      s[16]   = crc;
      s[17]   = (len < 64);
      return s;
   endfunction

   task automatic push_byte(input logic [7:0] b, input bit last, input bit crc);
      rx_valid = 1'b1; rx_data = b; rx_last = last; rx_crc_err = crc;
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0;
   endtask

   task automatic send_range(input int from, input int to, input int len, input bit crc, input bit gaps);
      for (int i = from; i < to; i++) begin
         push_byte(fr[i], i == len - 1, crc);
         if (gaps && ($urandom % 4 == 0)) @(negedge clk);
      end
   endtask

   task automatic read_word(output logic [63:0] d, output logic [7:0] bv, output logic e);
      d = host_data; bv = host_bvalid; e = host_eof;
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic fill(input int len);
      for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
   endtask

   // Drains one frame and compares data (R2), lane flags (R3), eof (R9) and status (R8, R7).
   task automatic drain_frame(input int len, input bit crc, input string tag);
      logic [63:0] d; logic [7:0] bv; logic e;
      int nw = (len + 7) / 8;
      for (int w = 0; w < nw; w++) begin
         read_word(d, bv, e);
         check(d == exp_data(len, w), {"R2 data ", tag}, d, exp_data(len, w));
         check(bv == exp_bv(len, w), {"R3 bvalid ", tag}, 64'(bv), 64'(exp_bv(len, w)));
         check(e == (w == nw - 1 && !cfg_status_en), {"R9 eof ", tag}, 64'(e), 64'(w == nw - 1 && !cfg_status_en));
      end
      if (cfg_status_en) begin
         read_word(d, bv, e);
         check(d == exp_status(len, crc) && bv == 8'hFF, {"R8 status ", tag}, d, exp_status(len, crc));
         check(e == 1'b1, {"R9 status eof ", tag}, 64'(e), 64'd1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] d; logic [7:0] bv; logic e;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(host_ready == 0 && host_bvalid == 0 && host_eof == 0 && ovf_flag == 0,
            "R1 reset", {host_ready, host_eof, ovf_flag, host_bvalid}, 64'd0);

      // R10: read strobe with nothing readable
      host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
      check(host_bvalid == 0, "R10 empty read", 64'(host_bvalid), 64'd0);

      // R4: 32-byte burst threshold
      fill(43);
      send_range(0, 31, 43, 0, 0);
      check(host_ready == 0, "R4 below 32", 64'(host_ready), 64'd0);
      send_range(31, 32, 43, 0, 0);
      check(host_ready == 1, "R4 at 32", 64'(host_ready), 64'd1);
      send_range(32, 43, 43, 0, 0);
      drain_frame(43, 0, "f43");
      check(host_ready == 0 && host_bvalid == 0, "R10 drained", 64'(host_bvalid), 64'd0);

      // R4: 64-byte burst threshold
      cfg_burst_sel = 1'b1;
      fill(70);
      send_range(0, 63, 70, 0, 0);
      check(host_ready == 0, "R4 below 64", 64'(host_ready), 64'd0);
      send_range(63, 64, 70, 0, 0);
      check(host_ready == 1, "R4 at 64", 64'(host_ready), 64'd1);
      send_range(64, 70, 70, 0, 0);
      drain_frame(70, 0, "f70");

      // R5, R7, R8: short frame delivered with status
      cfg_status_en = 1'b1;
      fill(10);
      send_range(0, 9, 10, 1, 0);
      check(host_ready == 0, "R5 before eof", 64'(host_ready), 64'd0);
      send_range(9, 10, 10, 1, 0);
      check(host_ready == 1, "R5 at eof", 64'(host_ready), 64'd1);
      drain_frame(10, 1, "R7 runt delivered");

      // R6: hold-off drops a 63-byte frame
      cfg_holdoff_en = 1'b1; cfg_burst_sel = 1'b0;
      fill(63);
      send_range(0, 40, 63, 0, 0);
      check(host_ready == 0 && host_bvalid == 0, "R6 withheld", 64'(host_bvalid), 64'd0);
      send_range(40, 63, 63, 0, 0);
      check(host_ready == 0 && host_bvalid == 0, "R6 runt removed", 64'(host_bvalid), 64'd0);
      fill(80);
      send_range(0, 63, 80, 1, 0);
      check(host_ready == 0, "R6 at 63 bytes", 64'(host_ready), 64'd0);
      send_range(63, 64, 80, 1, 0);
      check(host_ready == 1, "R6 released at 64", 64'(host_ready), 64'd1);
      send_range(64, 80, 80, 1, 0);
      drain_frame(80, 1, "R6 f80");

      // R11: overflow with an earlier frame waiting
      cfg_holdoff_en = 1'b0; cfg_status_en = 1'b0;
      fill(20);
      send_range(0, 20, 20, 0, 0);
      begin
         logic [7:0] keep [20];
         for (int i = 0; i < 20; i++) keep[i] = fr[i];
         fill(200);
         ovf_seen = 0;
         send_range(0, 200, 200, 0, 0);
         @(negedge clk);
         check(ovf_seen == 1, "R11 one pulse", 64'(ovf_seen), 64'd1);
         check(ovf_flag == 0, "R11 pulse ends", 64'(ovf_flag), 64'd0);
         for (int i = 0; i < 20; i++) fr[i] = keep[i];
         drain_frame(20, 0, "R11 earlier frame");
         check(host_bvalid == 0, "R11 dropped frame gone", 64'(host_bvalid), 64'd0);
      end
      fill(30);
      send_range(0, 30, 30, 0, 0);
      drain_frame(30, 0, "R11 next frame");

      // random frames
      for (int f = 0; f < 40; f++) begin
         int len = 1 + int'($urandom % 112);
         bit crc = 1'($urandom);
         cfg_holdoff_en = 1'($urandom);
         cfg_status_en  = 1'($urandom);
         cfg_burst_sel  = 1'($urandom);
         if (f % 8 == 0) len = (f % 16 == 0) ? 63 : 64;
         fill(len);
         send_range(0, len, len, crc, 1);
         if (cfg_holdoff_en && len < 64) begin
            check(host_ready == 0 && host_bvalid == 0, "R6 random runt", 64'(host_bvalid), 64'd0);
         end else begin
            check(host_ready == 1, "R5 random eof", 64'(host_ready), 64'd1);
            drain_frame(len, crc, "random");
         end
         check(host_bvalid == 0, "R10 random empty", 64'(host_bvalid), 64'd0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule